// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address for each beat of a four-beat burst into a synchronous memory. When either of two active-low address strobes is sampled low, it captures a fresh base address. On later edges it moves to the next beat whenever the active-low advance input is low and both strobes are high. In every other case it keeps the current beat. Only the two lowest address bits ever change. The upper bits always come from the captured base, whatever the address input does after the capture.

A static order input picks the beat sequence, and the block reads it only at the moment of capture. A high level gives the interleaved order, where each beat's low bits are the base low bits XOR the beat count. A low level gives the linear order, where each beat's low bits are the base low bits plus the beat count, wrapped within the group of four. After the fourth beat, one more advance returns to the base address. The address output comes straight from the registers, so it shows the new beat right after the edge that produced it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and until the first capture after reset, `burst_addr` reads all zeros.
- R2: A rising clock edge with `strobe_a_n` low, `strobe_b_n` low, or both low captures `addr_in`. From that edge on, `burst_addr` equals the captured value, which is beat 0.
- R3: On an edge that captures, `adv_n` has no effect: `burst_addr` equals the captured base even when `adv_n` is low.
- R4: A rising edge with both strobes high and `adv_n` low moves the burst to the next beat.
- R5: A rising edge with both strobes high and `adv_n` high leaves `burst_addr` unchanged.
- R6: With `order_sel` = 1 at capture (interleaved), the low two bits at beat k are base[1:0] XOR k. From base low bits 01 the beats are 01, 00, 11, 10.
- R7: With `order_sel` = 0 at capture (linear), the low two bits at beat k are (base[1:0] + k) mod 4. From base low bits 01 the beats are 01, 10, 11, 00.
- R8: An advance from the fourth beat (k = 3) returns `burst_addr` to the captured base.
- R9: During a burst, `burst_addr` bits above bit 1 equal the captured base, whatever `addr_in` does afterwards.
- R10: `order_sel` is sampled only on capturing edges. Changing it during a burst does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strobe_a_n | input | 1 | First address strobe, active low, captures `addr_in` |
| strobe_b_n | input | 1 | Second address strobe, active low, captures `addr_in` |
| adv_n | input | 1 | Advance, active low, steps to the next beat when both strobes are high |
| order_sel | input | 1 | Beat order at capture: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | Base address offered for capture |
| burst_addr | output | ADDR_W | Address of the current beat |

## Verification
Every result is due one clock edge after its stimulus. Strobes, advance, order and address are driven on a falling edge. The next rising edge updates the beat count and the captured base. `burst_addr` is read 2 ns after that rising edge, well before the next falling edge changes the inputs. Reset release goes through a two-stage synchronizer, so the bench keeps the inputs idle for three edges after reset before it issues the first capture. Expected addresses come from the XOR and modulo-four sums in the requirements, and the base-01 sequences are also checked against fixed literal lists.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Action decoded from the strobes and advance on one edge
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } burst_act_t;

  // Beat order; encoding matches the order_sel pin level
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_t;

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/burst_decode.sv
module burst_decode
  import burst_pkg::*;
(
  input  logic       strobe_a_n,
  input  logic       strobe_b_n,
  input  logic       adv_n,
  output burst_act_t act
);

  // Either strobe wins over advance; advance only counts with both strobes idle
  always_comb begin
    if (!strobe_a_n || !strobe_b_n) act = ACT_LOAD;
    else if (!adv_n)                act = ACT_STEP;
    else                            act = ACT_HOLD;
  end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_in,
  output logic [ADDR_W-1:0] base_q,
  output burst_order_t      order_q
);

  logic [ADDR_W-1:0] base_d;
  burst_order_t      order_d;

  always_comb begin
    base_d  = base_q;
    order_d = order_q;
    if (load_en) begin
      base_d  = addr_in;
      order_d = burst_order_t'(order_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVE;
    end else begin
      base_q  <= base_d;
      order_q <= order_d;
    end
  end

  AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(base_q)); // R9

  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(order_q)); // R10

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_act_t        act,
  output logic [BEAT_W-1:0] beat_q
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] beat_d;

  // Counter wraps naturally at the burst length
  always_comb begin
    case (act)
      ACT_LOAD: beat_d = '0;
      ACT_STEP: beat_d = beat_q + ONE;
      default:  beat_d = beat_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD) |=> (beat_q == '0)); // R2

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP) |=> (beat_q == BEAT_W'($past(beat_q) + ONE))); // R4

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HOLD) |=> $stable(beat_q)); // R5

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_lo,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_t      order,
  output logic [BEAT_W-1:0] addr_lo
);

  logic [BEAT_W-1:0] lo_intlv;
  logic [BEAT_W-1:0] lo_linear;

  // Interleaved: per-bit toggle by the beat count
  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign lo_intlv[b] = base_lo[b] ^ beat[b];
  end

  // Linear: sum truncated to the group size
  assign lo_linear = base_lo + beat;

  always_comb begin
    addr_lo = (order == ORD_INTERLEAVE) ? lo_intlv : lo_linear;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_a_n,
  input  logic              strobe_b_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] burst_addr
);

  localparam int BEAT_W = $clog2(BURST_LEN);

  logic              rst_sync_n;
  burst_act_t        act;
  logic [ADDR_W-1:0] base_q;
  burst_order_t      order_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] addr_lo;

  burst_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  burst_decode u_decode (
    .strobe_a_n (strobe_a_n),
    .strobe_b_n (strobe_b_n),
    .adv_n      (adv_n),
    .act        (act)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (act == ACT_LOAD),
    .addr_in  (addr_in),
    .order_in (order_sel),
    .base_q   (base_q),
    .order_q  (order_q)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .act    (act),
    .beat_q (beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base_lo (base_q[BEAT_W-1:0]),
    .beat    (beat_q),
    .order   (order_q),
    .addr_lo (addr_lo)
  );

  assign burst_addr = {base_q[ADDR_W-1:BEAT_W], addr_lo};

  AST_LOAD_SHOWS_BASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe_a_n || !strobe_b_n) |=> (burst_addr == $past(addr_in))); // R2

  AST_ADV_IGNORED_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strobe_a_n && !adv_n) |=> (burst_addr == $past(addr_in))); // R3

  AST_HOLD_STABLE_OUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_a_n && strobe_b_n && adv_n) |=> $stable(burst_addr)); // R5

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_a_n && strobe_b_n) |=>
      (burst_addr[ADDR_W-1:BEAT_W] == $past(burst_addr[ADDR_W-1:BEAT_W]))); // R9

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              strobe_a_n, strobe_b_n, adv_n, order_sel;
  logic [ADDR_W-1:0] addr_in;
  logic [ADDR_W-1:0] burst_addr;

  int checks = 0;
  int errors = 0;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_a_n (strobe_a_n),
    .strobe_b_n (strobe_b_n),
    .adv_n      (adv_n),
    .order_sel  (order_sel),
    .addr_in    (addr_in),
    .burst_addr (burst_addr)
  );

  always #5 clk = ~clk;

  // Drive on the falling edge, sample 2 ns after the rising edge
  task automatic cyc(input logic sa, input logic sb, input logic adv,
                     input logic ord, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    strobe_a_n = sa; strobe_b_n = sb; adv_n = adv; order_sel = ord; addr_in = a;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [ADDR_W-1:0] exp);
    checks++;
    if (burst_addr !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, burst_addr, exp);
    end
  endtask

  function automatic logic [1:0] exp_lo(input logic [1:0] b, input int k, input logic ord);
    logic [1:0] kk = 2'(k);
    return ord ? (b ^ kk) : 2'(b + kk);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; strobe_a_n = 1; strobe_b_n = 1; adv_n = 1; order_sel = 1; addr_in = '0;
    #12;
    chk("R1 in reset", '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) cyc(1, 1, 1, 1, 16'hFFFF);
    chk("R1 after release", '0);
  endtask

  task automatic t_interleave();
    logic [1:0] lit [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
    cyc(0, 1, 1, 1, 16'h1235);
    chk("R2 load strobe_a", 16'h1235);
    for (int k = 1; k < 4; k++) begin
      cyc(1, 1, 0, 1, 16'h0000);
      chk("R6 interleave beat", {14'(16'h1235 >> 2), lit[k]});
      chk("R4 step formula", {14'(16'h1235 >> 2), exp_lo(2'b01, k, 1'b1)});
    end
    cyc(1, 1, 0, 1, 16'h0000);
    chk("R8 wrap to base", 16'h1235);
  endtask

  task automatic t_linear();
    logic [1:0] lit [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
    cyc(1, 0, 1, 0, 16'h4C01);
    chk("R2 load strobe_b", 16'h4C01);
    for (int k = 1; k < 4; k++) begin
      cyc(1, 1, 0, 0, 16'hFFFF);
      chk("R7 linear beat", {14'(16'h4C01 >> 2), lit[k]});
    end
    cyc(1, 1, 0, 0, 16'hFFFF);
    chk("R8 linear wrap", 16'h4C01);
    for (int b = 0; b < 4; b++) begin
      cyc(0, 0, 1, 0, 16'(16'h0F00 | b));
      for (int k = 1; k < 4; k++) begin
        cyc(1, 1, 0, 0, 16'h0000);
        chk("R7 linear from each base", {14'(16'h0F00 >> 2), exp_lo(2'(b), k, 1'b0)});
      end
    end
  endtask

  task automatic t_load_adv();
    cyc(0, 1, 1, 1, 16'h2002);
    cyc(1, 1, 0, 1, 16'h0000);
    cyc(0, 1, 0, 1, 16'h3003);
    chk("R3 adv ignored strobe_a", 16'h3003);
    cyc(1, 0, 0, 0, 16'h7771);
    chk("R3 adv ignored strobe_b", 16'h7771);
  endtask

  task automatic t_hold();
    cyc(0, 1, 1, 0, 16'h00A2);
    cyc(1, 1, 0, 0, 16'h0000);
    chk("R4 linear step", 16'h00A3);
    cyc(1, 1, 1, 0, 16'h5555);
    chk("R5 hold 1", 16'h00A3);
    cyc(1, 1, 1, 1, 16'hAAAA);
    chk("R5 hold 2", 16'h00A3);
    cyc(1, 1, 0, 0, 16'h0000);
    chk("R4 step after hold", 16'h00A0);
  endtask

  task automatic t_upper_mode();
    cyc(0, 1, 1, 1, 16'hABC1);
    cyc(1, 1, 0, 0, 16'h5552);
    chk("R10 order change ignored b1", 16'hABC0);
    cyc(1, 1, 0, 0, 16'h0003);
    chk("R9 upper kept b2", 16'hABC3);
    cyc(1, 1, 0, 1, 16'hFFFF);
    chk("R10 beat3", 16'hABC2);
  endtask

  initial begin
    t_reset();
    t_interleave();
    t_linear();
    t_load_adv();
    t_hold();
    t_upper_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule